// File: doc/BRIEF.md
# Burst Memory Address and Select Controller

This block sits at the front of a synchronous burst static memory. On every rising clock edge it decides whether a new external address is taken, whether the device is selected or deselected, and whether a burst already in progress steps forward. Two address strobes are provided: one meant for a processor and one for a cache controller. The processor strobe has priority, but it only counts while the first enable input is active. The three enable inputs are looked at only in a cycle where a strobe is accepted. At all other times the block keeps its previous select state.

The captured address is held in a register. The two lowest address bits act as the starting offset of a four-word burst. A two-bit counter advances on each edge where the step input is low and the device is selected, and it wraps from 3 to 0. A static order input chooses how the offset is applied. In linear order the low bits are the start plus the count, modulo 4. In interleaved order they are the start XOR the count. The block drives three outputs: the current internal word address, a selected flag, and a cycle-kind code that tells downstream read and write logic what the last edge did.

Top module: `burst_addr_ctl`

## Requirements
- R1: While rst is high, and after it is released with no other activity, word_addr is 0, selected is 0 and cyc_kind is 2'b00 (hold).
- R2: An accepted strobe with all enables active (en_a_n low, en_b high, en_c_n low) gives the following on the next edge: word_addr equals the sampled addr, selected is 1 and cyc_kind is 2'b01 (new address). A strobe is accepted when ctrl_stb_n is low, or when proc_stb_n is low while en_a_n is low.
- R3: While en_a_n is high, a low proc_stb_n has no effect. If ctrl_stb_n is high, the edge behaves exactly as if no strobe were present.
- R4: When both strobes are low, only the processor strobe is acted on. If en_a_n is high, the processor strobe is dropped and the controller strobe is taken, which deselects the device (cyc_kind 2'b11).
- R5: The enable inputs change neither selected nor word_addr on any edge where no strobe is accepted.
- R6: On an edge with no accepted strobe, step_n low and selected high, the burst count steps once and cyc_kind is 2'b10 (burst continue). The address bits above the lowest two stay the same.
- R7: With order_interleave low, the two low bits of word_addr are (start + count) mod 4, so they wrap from 3 to 0.
- R8: With order_interleave high, the two low bits of word_addr are start XOR count, giving for example the order 2, 3, 0, 1 from a start of 2.
- R9: On an edge with no accepted strobe and either step_n high or selected low, word_addr and selected hold their values and cyc_kind is 2'b00.
- R10: An accepted strobe with any enable inactive clears selected, sets cyc_kind to 2'b11 (deselect) and leaves word_addr unchanged. Later step_n pulses do nothing until a new address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by en_a_n |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Enable A, active low |
| en_b | input | 1 | Enable B, active high |
| en_c_n | input | 1 | Enable C, active low |
| order_interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | AW | External word address |
| word_addr | output | AW | Current internal word address |
| selected | output | 1 | Device selected flag |
| cyc_kind | output | 2 | Last edge: 00 hold, 01 new, 10 burst, 11 deselect |

## Verification
The case that is hardest to reach from the ports is the interaction between the two strobes. A low processor strobe with the first enable high must be dropped, and in the same cycle a controller strobe must be taken and must deselect the device. Random stimulus rarely hits this combination while a burst is under way, so directed sequences set it up directly. They open a burst, advance it across the 3-to-0 wrap in both orders, then apply the masked processor strobe alone and together with the controller strobe. Biased random cycles then mix strobes, enables and steps, so that enable changes land on cycles with no accepted strobe.

// File: rtl/bac_pkg.sv
package bac_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_HOLD  = 2'b00,
        CYC_NEW   = 2'b01,
        CYC_BURST = 2'b10,
        CYC_DESEL = 2'b11
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic take_addr;
        logic step;
        logic set_sel;
        logic clr_sel;
    } decide_s;

    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input logic               interleave
    );
        if (interleave) return start ^ count;
        return start + count;
    endfunction

endpackage

// File: rtl/bac_strobe_decode.sv
module bac_strobe_decode
    import bac_pkg::*;
(
    input  logic    proc_stb_n,
    input  logic    ctrl_stb_n,
    input  logic    step_n,
    input  logic    en_a_n,
    input  logic    en_b,
    input  logic    en_c_n,
    input  logic    sel_q,
    output decide_s dec
);
    logic proc_take;
    logic ctrl_take;
    logic load;
    logic enables_ok;

    always_comb begin
        // processor strobe is masked by enable A; it wins over the controller
        proc_take  = !proc_stb_n && !en_a_n;
        ctrl_take  = !ctrl_stb_n && !proc_take;
        load       = proc_take || ctrl_take;
        enables_ok = !en_a_n && en_b && !en_c_n;

        dec = '{kind: CYC_HOLD, take_addr: 1'b0, step: 1'b0,
                set_sel: 1'b0, clr_sel: 1'b0};
        if (load && enables_ok) begin
            dec.kind      = CYC_NEW;
            dec.take_addr = 1'b1;
            dec.set_sel   = 1'b1;
        end else if (load) begin
            dec.kind    = CYC_DESEL;
            dec.clr_sel = 1'b1;
        end else if (sel_q && !step_n) begin
            dec.kind = CYC_BURST;
            dec.step = 1'b1;
        end
    end
endmodule

// File: rtl/bac_select_reg.sv
module bac_select_reg
    import bac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  decide_s dec,
    output logic    sel_q,
    output cyc_e    kind_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            kind_q <= CYC_HOLD;
        end else begin
            kind_q <= dec.kind;
            if (dec.set_sel)      sel_q <= 1'b1;
            else if (dec.clr_sel) sel_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bac_addr_burst.sv
module bac_addr_burst
    import bac_pkg::*;
#(
    parameter int AW             = 20,
    parameter bit INTERLEAVE_EN  = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  decide_s       dec,
    input  logic [AW-1:0] addr,
    input  logic          order_interleave,
    output logic [AW-1:0] word_addr
);
    localparam int UPPER_W = AW - BURST_W;

    logic [UPPER_W-1:0] upper_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] count_q;
    logic               use_xor;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            start_q <= '0;
            count_q <= '0;
        end else if (dec.take_addr) begin
            upper_q <= addr[AW-1:BURST_W];
            start_q <= addr[BURST_W-1:0];
            count_q <= '0;
        end else if (dec.step) begin
            count_q <= count_q + 1'b1;
        end
    end

    generate
        if (INTERLEAVE_EN) begin : g_mode_sel
            assign use_xor = order_interleave;
        end else begin : g_mode_lin
            assign use_xor = 1'b0 & order_interleave;
        end
    endgenerate

    assign word_addr = {upper_q, burst_low(start_q, count_q, use_xor)};
endmodule

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
    import bac_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          proc_stb_n,
    input  logic          ctrl_stb_n,
    input  logic          step_n,
    input  logic          en_a_n,
    input  logic          en_b,
    input  logic          en_c_n,
    input  logic          order_interleave,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] word_addr,
    output logic          selected,
    output logic [1:0]    cyc_kind
);
    decide_s dec;
    logic    sel_q;
    cyc_e    kind_q;

    bac_strobe_decode u_dec (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .step_n     (step_n),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .sel_q      (sel_q),
        .dec        (dec)
    );

    bac_select_reg u_sel (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .sel_q  (sel_q),
        .kind_q (kind_q)
    );

    bac_addr_burst #(.AW(AW), .INTERLEAVE_EN(1'b1)) u_addr (
        .clk              (clk),
        .rst              (rst),
        .dec              (dec),
        .addr             (addr),
        .order_interleave (order_interleave),
        .word_addr        (word_addr)
    );

    assign selected = sel_q;
    assign cyc_kind = kind_q;
endmodule

// File: rtl/burst_addr_ctl_chk.sv
module burst_addr_ctl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          proc_stb_n,
    input logic          ctrl_stb_n,
    input logic          step_n,
    input logic          en_a_n,
    input logic          en_b,
    input logic          en_c_n,
    input logic          order_interleave,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] word_addr,
    input logic          selected,
    input logic [1:0]    cyc_kind
);
    logic acc, en_all;
    assign acc    = (!proc_stb_n && !en_a_n) || !ctrl_stb_n;
    assign en_all = !en_a_n && en_b && !en_c_n;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (word_addr == '0 && !selected && cyc_kind == 2'b00));

    assert_new_load_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && en_all) |=> (word_addr == $past(addr) && selected && cyc_kind == 2'b01));

    assert_masked_proc_R3: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && en_a_n && ctrl_stb_n) |=> (cyc_kind != 2'b01 && cyc_kind != 2'b11));

    assert_ctrl_when_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && en_a_n && !ctrl_stb_n) |=> (cyc_kind == 2'b11 && !selected));

    assert_enables_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(selected));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!acc && selected && !step_n) |=>
        (cyc_kind == 2'b10 && word_addr[AW-1:2] == $past(word_addr[AW-1:2])));

    assert_linear_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!acc && selected && !step_n && !order_interleave) |=>
        (order_interleave || word_addr[1:0] == $past(word_addr[1:0]) + 2'd1));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!acc && (step_n || !selected)) |=>
        (cyc_kind == 2'b00 && (!$stable(order_interleave) || $stable(word_addr))));

    assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && !en_all) |=>
        (!selected && cyc_kind == 2'b11 && (!$stable(order_interleave) || $stable(word_addr))));
endmodule

bind burst_addr_ctl burst_addr_ctl_chk #(.AW(AW)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .proc_stb_n       (proc_stb_n),
    .ctrl_stb_n       (ctrl_stb_n),
    .step_n           (step_n),
    .en_a_n           (en_a_n),
    .en_b             (en_b),
    .en_c_n           (en_c_n),
    .order_interleave (order_interleave),
    .addr             (addr),
    .word_addr        (word_addr),
    .selected         (selected),
    .cyc_kind         (cyc_kind)
);

// File: tb/burst_addr_ctl_tb_top.sv
module burst_addr_ctl_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, step_n = 1'b1;
    logic          en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
    logic          order_interleave = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] word_addr;
    logic          selected;
    logic [1:0]    cyc_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic          m_sel = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [1:0]    m_kind = 2'b00;

    always #4 clk = ~clk;

    burst_addr_ctl #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .step_n(step_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .order_interleave(order_interleave), .addr(addr),
        .word_addr(word_addr), .selected(selected), .cyc_kind(cyc_kind)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_interleave ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (word_addr !== exp_addr() || selected !== m_sel || cyc_kind !== m_kind) begin
            fails++;
            $display("FAIL %s: got addr=%h sel=%b kind=%b, expected addr=%h sel=%b kind=%b",
                     tag, word_addr, selected, cyc_kind, exp_addr(), m_sel, m_kind);
        end
    endtask

    // drive one cycle, update the model at the edge, compare at the falling edge
    task automatic cyc(input logic ps, input logic cs, input logic st,
                       input logic ea, input logic eb, input logic ec,
                       input logic [AW-1:0] a);
        logic pt, ld, ok;
        string tag;
        proc_stb_n = ps; ctrl_stb_n = cs; step_n = st;
        en_a_n = ea; en_b = eb; en_c_n = ec; addr = a;
        @(posedge clk);
        pt = !ps && !ea;
        ld = pt || !cs;
        ok = !ea && eb && !ec;
        if (ld && ok) begin
            m_base = a; m_cnt = '0; m_sel = 1'b1; m_kind = 2'b01; tag = "R2";
        end else if (ld) begin
            m_sel = 1'b0; m_kind = 2'b11; tag = "R10";
        end else if (m_sel && !st) begin
            m_cnt = m_cnt + 2'd1; m_kind = 2'b10;
            tag = order_interleave ? "R8" : "R7";
        end else begin
            m_kind = 2'b00; tag = (ea != en_a_n || eb || !ec) ? "R5" : "R9";
        end
        if (!ps && ea && cs)  tag = "R3";
        if (!ps && !cs)       tag = "R4";
        @(negedge clk);
        check(tag);
    endtask

    task automatic load(input logic [AW-1:0] a);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, a);
    endtask

    task automatic adv(input string unused_tag);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1");

        // R2 / R7: linear burst from start 3 wraps 3,0,1,2,3
        order_interleave = 1'b0;
        load(20'hABCD7);
        for (int i = 0; i < 5; i++) adv("R7");
        // R9: hold with step high
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 20'h11111);
        // R5: enables toggled with no strobe
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 20'h22222);

        // R8: interleaved from start 2 gives 2,3,0,1
        order_interleave = 1'b1;
        load(20'h5A5A6);
        for (int i = 0; i < 4; i++) adv("R8");

        // R3: masked processor strobe alone, with step low it just bursts
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 20'h33333);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 20'h33333);
        // R4: both strobes, enable A active -> new address
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h44441);
        // R4: both strobes, enable A high -> controller deselects
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'h55555);
        // R10: advance ignored while deselected
        adv("R10");
        adv("R10");
        // R10: controller strobe with enable C inactive
        order_interleave = 1'b0;
        load(20'h00002);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 20'h77777);
        // R2: controller strobe with all enables active
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h8888B);
        adv("R7");

        // biased random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) order_interleave = $urandom_range(0, 1);
            cyc(($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1,
                ($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1,
                ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1,
                ($urandom_range(0, 9) < 3) ? 1'b1 : 1'b0,
                ($urandom_range(0, 9) < 8) ? 1'b1 : 1'b0,
                ($urandom_range(0, 9) < 2) ? 1'b1 : 1'b0,
                AW'($urandom));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule